// File: doc/BRIEF.md
# Prescaled One-Shot / Periodic Down Counter

This block is a 16-bit down counter with an 8-bit prescaler. It runs from the system clock and is set up through a small register port. Software stores a start value, picks one of two end-of-count behaviours with a mode code, and may set a prescale divisor. The counter only runs when the top-level configuration code selects split 16-bit operation. Writing the enable bit loads the start value and starts the count.

When the count reaches zero, a sticky timeout flag is set. Software clears it by writing 1. An interrupt mask bit passes the flag to the `irq` output. In single-run mode the hardware clears the enable bit at timeout, so software must re-arm the counter. In repeating mode the start value is reloaded on the next count step and counting goes on. The configuration registers are frozen while the counter is enabled.

Register map (4-bit word address, 16-bit data, bit 0 unless noted):
- 0: configuration code, bits [2:0]
- 1: mode, bits [1:0]
- 2: enable
- 3: start value, bits [15:0]
- 4: prescale, bits [7:0]
- 5: interrupt mask
- 6: raw timeout flag (read-only)
- 7: flag clear (write-only, reads 0)
- 8: current count (read-only)
- 9: masked flag (read-only)

Reads are registered: `reg_rdata` shows the addressed register one clock after the address is presented. A write is taken on any clock edge where `reg_wr` is high.

Top module: `ptmr_top`

## Requirements
- R1: After reset, every register reads 0, the count reads 0 and `irq` is low.
- R2: While enable is 1, writes to configuration (0), mode (1), start value (3) and prescale (4) are ignored, so read-back keeps the old value.
- R3: Setting enable loads the start value into the count. The count then moves only if configuration is 4 and mode is 1 or 2. Any other configuration or mode leaves the count at the start value.
- R4: In mode 1 (single run) with start value L and prescale P, the flag is set on the L·(P+1)-th clock edge after the edge that took the enable write. On that same edge the enable bit reads 0 and the count stays 0.
- R5: In mode 2 (repeating), the count reloads L on the next count step after zero. Later timeouts are (L+1)·(P+1) edges apart, and enable stays 1.
- R6: A prescale value P gives one count step every P+1 clocks. P = 0 steps the count on every clock.
- R7: The timeout flag (address 6, bit 0) stays set until 1 is written to bit 0 of address 7. Writing 0 there has no effect.
- R8: `irq` and the masked flag (address 9) equal flag AND mask (address 5, bit 0). `irq` changes on the same edge as the flag or the mask.
- R9: A start value of 0 produces a timeout on the first count step after enable, (P+1) edges after the enable write.
- R10: Writing enable to 0 freezes the count at its current value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq | output | 1 | Masked timeout interrupt, registered |

## Verification
A prescaler phase or count that is off by one shows up at `irq` as a timeout that comes exactly P+1 or one clock early or late, on the first timeout after enable. The bench therefore checks `irq` on the exact edge it is due and on the edge before it. A wrong reload or a wrong enable state shows up at the second periodic timeout, or within one read of the enable and count registers. A flag that is not held or not cleared correctly shows at `irq` one clock after the stray event.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CFG   = 4'd0;
  localparam logic [ADDR_W-1:0] A_MODE  = 4'd1;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd2;
  localparam logic [ADDR_W-1:0] A_LOAD  = 4'd3;
  localparam logic [ADDR_W-1:0] A_PRESC = 4'd4;
  localparam logic [ADDR_W-1:0] A_MASK  = 4'd5;
  localparam logic [ADDR_W-1:0] A_RAW   = 4'd6;
  localparam logic [ADDR_W-1:0] A_CLR   = 4'd7;
  localparam logic [ADDR_W-1:0] A_COUNT = 4'd8;
  localparam logic [ADDR_W-1:0] A_MSTAT = 4'd9;

  localparam int CFG_W  = 3;
  localparam int MODE_W = 2;
  localparam logic [CFG_W-1:0]  CFG_SPLIT16   = 3'd4;
  localparam logic [MODE_W-1:0] MODE_ONESHOT  = 2'd1;
  localparam logic [MODE_W-1:0] MODE_PERIODIC = 2'd2;
endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic [PRE_W-1:0] presc,
  output logic             tick
);
  logic [PRE_W-1:0] pcnt_q, pcnt_d;

  always_comb begin
    pcnt_d = pcnt_q;
    tick   = 1'b0;
    if (start) begin
      pcnt_d = presc;
    end else if (run) begin
      if (pcnt_q == '0) begin
        pcnt_d = presc;
        tick   = 1'b1;
      end else begin
        pcnt_d = pcnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pcnt_q <= '0;
    else     pcnt_q <= pcnt_d;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    (tick && presc != '0 && $stable(presc)) |=> !tick); // R6

endmodule

// File: rtl/ptmr_core.sv
module ptmr_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             tick,
  input  logic             periodic,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             tmo
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    tmo   = 1'b0;
    if (start) begin
      cnt_d = load_val;
    end else if (tick) begin
      if (cnt_q == ONE) begin
        cnt_d = '0;
        tmo   = 1'b1;
      end else if (cnt_q == '0) begin
        tmo = (load_val == '0);
        if (periodic) cnt_d = load_val;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!start && !tick) |=> $stable(cnt_q)); // R10
  AST_ZERO_AFTER_TMO: assert property (@(posedge clk) disable iff (rst)
    tmo |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              tmo,
  input  logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq,
  output logic              start,
  output logic              run,
  output logic              periodic,
  output logic [CNT_W-1:0]  load_val,
  output logic [PRE_W-1:0]  presc_val
);
  logic [CFG_W-1:0]  cfg_q;
  logic [MODE_W-1:0] mode_q;
  logic              en_q, en_d;
  logic [CNT_W-1:0]  load_q;
  logic [PRE_W-1:0]  presc_q;
  logic              mask_q, mask_d;
  logic              flag_q, flag_d;
  logic              irq_q;
  logic [CNT_W-1:0]  rdata_q, rdata_d;
  logic              frozen_wr, clr_hit, hw_stop, mode_ok, cfg_ok;

  always_comb begin
    frozen_wr = wr && !en_q;
    clr_hit   = wr && (addr == A_CLR) && wdata[0];
    hw_stop   = tmo && (mode_q == MODE_ONESHOT);
    mode_ok   = (mode_q == MODE_ONESHOT) || (mode_q == MODE_PERIODIC);
    cfg_ok    = (cfg_q == CFG_SPLIT16);
    start     = wr && (addr == A_CTRL) && wdata[0] && !en_q;
    en_d      = en_q;
    if (wr && addr == A_CTRL) en_d = wdata[0];
    if (hw_stop)              en_d = 1'b0;
    flag_d = tmo | (flag_q & ~clr_hit);
    mask_d = (wr && addr == A_MASK) ? wdata[0] : mask_q;
  end

  always_comb begin
    rdata_d = '0;
    case (addr)
      A_CFG:   rdata_d = CNT_W'(cfg_q);
      A_MODE:  rdata_d = CNT_W'(mode_q);
      A_CTRL:  rdata_d = CNT_W'(en_q);
      A_LOAD:  rdata_d = load_q;
      A_PRESC: rdata_d = CNT_W'(presc_q);
      A_MASK:  rdata_d = CNT_W'(mask_q);
      A_RAW:   rdata_d = CNT_W'(flag_q);
      A_COUNT: rdata_d = count;
      A_MSTAT: rdata_d = CNT_W'(flag_q & mask_q);
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      mode_q  <= '0;
      en_q    <= 1'b0;
      load_q  <= '0;
      presc_q <= '0;
      mask_q  <= 1'b0;
      flag_q  <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (frozen_wr && addr == A_CFG)   cfg_q   <= wdata[CFG_W-1:0];
      if (frozen_wr && addr == A_MODE)  mode_q  <= wdata[MODE_W-1:0];
      if (frozen_wr && addr == A_LOAD)  load_q  <= wdata;
      if (frozen_wr && addr == A_PRESC) presc_q <= wdata[PRE_W-1:0];
      en_q    <= en_d;
      mask_q  <= mask_d;
      flag_q  <= flag_d;
      irq_q   <= flag_d & mask_d;
      rdata_q <= rdata_d;
    end
  end

  assign run       = en_q && cfg_ok && mode_ok;
  assign periodic  = (mode_q == MODE_PERIODIC);
  assign load_val  = load_q;
  assign presc_val = presc_q;
  assign rdata     = rdata_q;
  assign irq       = irq_q;

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (en_q && wr && addr == A_LOAD) |=> $stable(load_q)); // R2
  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (rst)
    (tmo && mode_q == MODE_ONESHOT) |=> !en_q); // R4
  AST_PERIODIC_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (tmo && mode_q == MODE_PERIODIC && !(wr && addr == A_CTRL)) |=> en_q); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_hit) |=> flag_q); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (flag_q && mask_q)); // R8

endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              irq
);
  logic             start, run, periodic, tick, tmo;
  logic [CNT_W-1:0] load_val, count;
  logic [PRE_W-1:0] presc_val;

  initial begin
    if (PRE_W > CNT_W || CNT_W < CFG_W)
      $error("ptmr_top: PRE_W must not exceed CNT_W and CNT_W must hold the config code");
  end

  ptmr_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .tmo(tmo), .count(count), .rdata(reg_rdata), .irq(irq), .start(start),
    .run(run), .periodic(periodic), .load_val(load_val), .presc_val(presc_val)
  );

  ptmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .start(start), .run(run), .presc(presc_val), .tick(tick)
  );

  ptmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .start(start), .tick(tick), .periodic(periodic),
    .load_val(load_val), .count(count), .tmo(tmo)
  );

endmodule

// File: tb/test_ptmr_top.sv
module test_ptmr_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;
  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  ptmr_top i_ptmr_top (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk); #1;
    d = reg_rdata;
  endtask

  task automatic setup(input logic [15:0] cfg, input logic [15:0] mode,
                       input logic [15:0] load, input logic [15:0] pre, input logic m);
    wr(4'd2, 16'd0);
    wr(4'd0, cfg); wr(4'd1, mode); wr(4'd3, load); wr(4'd4, pre);
    wr(4'd5, {15'd0, m}); wr(4'd7, 16'd1);
  endtask

  // enable, then expect irq to rise exactly n edges after the enable edge
  task automatic start_and_time(input string req, input int n);
    wr(4'd2, 16'd1);
    repeat (n - 1) @(posedge clk);
    #1 check({req, " irq early"}, {15'd0, irq}, 16'd0);
    @(posedge clk); #1 check({req, " irq on time"}, {15'd0, irq}, 16'd1);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 irq", {15'd0, irq}, 16'd0);
    for (int a = 0; a < 10; a++) begin
      rd(a[3:0], d);
      check("R1 reg", d, 16'd0);
    end
  endtask

  task automatic t_oneshot();
    logic [15:0] d;
    setup(16'd4, 16'd1, 16'd5, 16'd0, 1'b1);
    start_and_time("R4 one-shot L5 P0", 5);
    rd(4'd2, d); check("R4 enable self-cleared", d, 16'd0);
    repeat (6) @(posedge clk);
    rd(4'd8, d); check("R4 count held at zero", d, 16'd0);
    rd(4'd6, d); check("R7 flag sticky", d, 16'd1);
    wr(4'd7, 16'd0);
    rd(4'd6, d); check("R7 write 0 no effect", d, 16'd1);
    wr(4'd7, 16'd1);
    rd(4'd6, d); check("R7 cleared by 1", d, 16'd0);
    #1 check("R8 irq follows clear", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_prescale();
    setup(16'd4, 16'd1, 16'd3, 16'd2, 1'b1);
    start_and_time("R6 prescale P2 L3", 9);
  endtask

  task automatic t_periodic();
    logic [15:0] d;
    setup(16'd4, 16'd2, 16'd4, 16'd1, 1'b1);
    start_and_time("R5 first periodic", 8);
    wr(4'd7, 16'd1);
    #1 check("R7 clear in periodic", {15'd0, irq}, 16'd0);
    repeat (8) @(posedge clk);
    #1 check("R5 second timeout early", {15'd0, irq}, 16'd0);
    @(posedge clk); #1 check("R5 second timeout", {15'd0, irq}, 16'd1);
    rd(4'd2, d); check("R5 enable kept", d, 16'd1);
    wr(4'd2, 16'd0);
  endtask

  task automatic t_mask();
    logic [15:0] d;
    setup(16'd4, 16'd1, 16'd2, 16'd0, 1'b0);
    wr(4'd2, 16'd1);
    repeat (5) @(posedge clk);
    #1 check("R8 masked irq low", {15'd0, irq}, 16'd0);
    rd(4'd6, d); check("R8 raw set", d, 16'd1);
    rd(4'd9, d); check("R8 masked status 0", d, 16'd0);
    wr(4'd5, 16'd1);
    #1 check("R8 irq after unmask", {15'd0, irq}, 16'd1);
    rd(4'd9, d); check("R8 masked status 1", d, 16'd1);
  endtask

  task automatic t_frozen();
    logic [15:0] d, d2;
    setup(16'd4, 16'd2, 16'd100, 16'd0, 1'b0);
    wr(4'd2, 16'd1);
    wr(4'd3, 16'd7);
    wr(4'd4, 16'd5);
    wr(4'd1, 16'd1);
    rd(4'd3, d); check("R2 load frozen", d, 16'd100);
    rd(4'd4, d); check("R2 prescale frozen", d, 16'd0);
    rd(4'd1, d); check("R2 mode frozen", d, 16'd2);
    wr(4'd2, 16'd0);
    rd(4'd8, d);
    repeat (4) @(posedge clk);
    rd(4'd8, d2);
    check("R10 count frozen", d2, d);
    check("R10 count moved before stop", {15'd0, (d < 16'd100 && d != 16'd0)}, 16'd1);
  endtask

  task automatic t_badcfg();
    logic [15:0] d;
    setup(16'd0, 16'd1, 16'd9, 16'd0, 1'b1);
    wr(4'd2, 16'd1);
    repeat (12) @(posedge clk);
    rd(4'd8, d); check("R3 config 0 holds count", d, 16'd9);
    #1 check("R3 no irq", {15'd0, irq}, 16'd0);
    setup(16'd4, 16'd3, 16'd6, 16'd0, 1'b1);
    wr(4'd2, 16'd1);
    repeat (10) @(posedge clk);
    rd(4'd8, d); check("R3 mode 3 holds count", d, 16'd6);
    wr(4'd2, 16'd0);
  endtask

  task automatic t_load0();
    setup(16'd4, 16'd1, 16'd0, 16'd3, 1'b1);
    start_and_time("R9 zero start value", 4);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_oneshot();
    t_prescale();
    t_periodic();
    t_mask();
    t_frozen();
    t_badcfg();
    t_load0();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 50000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule